// File: doc/BRIEF.md
# Generation-Tagged Device Context Cache

This block keeps one 128-bit translation context entry for each device. A device is addressed by a 16-bit source ID made of a bus number and a device/function number. A lookup presents a source ID and gets back, one cycle later, either a hit with the stored entry or a miss. On a miss the table-walk logic fetches the entry and writes it back through the fill port. If the fetch faulted, the fill is flagged and leaves the cache unchanged.

Entries are never invalidated by clearing a valid bit. Instead, each entry carries a generation tag and the block holds one global generation value. An entry hits only while its tag equals the global value. A global or domain flush bumps the global value, which makes every entry stale in a single cycle. A device-selective flush zeroes the tags of the selected devices, and a function mask can widen the selection to a group of functions. When the counter would reach its all-ones value, it restarts at 1 and a background sweep zeroes every tag, one entry per cycle. While the sweep runs, `busy` is high and both stream ports hold ready low.

Back-pressure rules:
- The lookup request and the fill each complete on a cycle where valid and ready are both high. The caller must hold valid and its payload until that cycle.
- The response stream has no ready. The consumer must accept `rsp_valid` in the cycle it is shown.
- Invalidation is a plain control input that acts in the cycle it is presented.

Top module: `ctx_cache`

## Requirements
- R1: After reset, `busy` is 0, `lk_ready` and `fill_ready` are 1, every lookup misses and the global generation is 1.
- R2: A lookup is accepted on a cycle with `lk_valid` and `lk_ready` both high. Exactly one cycle later, `rsp_valid` is high for one cycle and `rsp_sid` echoes the request. On a hit, `rsp_hit` is 1 and `rsp_entry` is the stored entry. On a miss, `rsp_hit` is 0 and `rsp_entry` is all zeros.
- R3: In a source ID, bits 15:8 are the bus and bits 7:0 are the devfn. Only the low BUS_BITS bus bits and the low DEVFN_BITS devfn bits select an entry, so source IDs that differ only in the upper bits share an entry.
- R4: A fill accepted with `fill_fault`=0 stores `fill_entry` together with the current generation. Later lookups of that entry then hit with that data.
- R5: A fill with `fill_fault`=1 changes nothing. An entry that held data keeps it and still hits.
- R6: `inv_kind`=2'b01 (global) advances the generation, so every entry misses until it is filled again.
- R7: `inv_kind`=2'b10 (domain) has exactly the same effect as a global flush.
- R8: `inv_kind`=2'b11 (device) zeroes the tags of all entries on the bus of `inv_sid` whose devfn equals the devfn of `inv_sid` once a compare mask is ignored. `inv_fmask` values 0, 1, 2 and 3 select compare masks 3'b000, 3'b100, 3'b110 and 3'b111. All other entries are unaffected.
- R9: `inv_kind`=2'b00 has no effect.
- R10: If an increment would make the generation equal to 2^GEN_W-1, the generation becomes 1 instead. `busy` is then high for exactly ENTRIES cycles while every tag is zeroed, and `lk_ready` and `fill_ready` are low throughout. Afterwards every entry misses.
- R11: A fill and an invalidation that hit the same entry in the same cycle leave that entry missing (the invalidation wins).
- R12: A lookup accepted in the same cycle as a fill or an invalidation observes the state from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready (low while busy) |
| lk_sid | input | 16 | Lookup source ID {bus, devfn} |
| rsp_valid | output | 1 | Lookup response valid, one cycle after acceptance |
| rsp_hit | output | 1 | Response is a hit |
| rsp_sid | output | 16 | Source ID of the answered lookup |
| rsp_entry | output | 128 | Cached entry on hit, zero on miss |
| fill_valid | input | 1 | Fill valid |
| fill_ready | output | 1 | Fill ready (low while busy) |
| fill_fault | input | 1 | Fetch faulted; fill discarded |
| fill_sid | input | 16 | Fill source ID |
| fill_entry | input | 128 | Fetched entry {high half, low half} |
| inv_kind | input | 2 | 00 none, 01 global, 10 domain, 11 device |
| inv_sid | input | 16 | Target source ID for device flush |
| inv_fmask | input | 2 | Function mask code for device flush |
| busy | output | 1 | Rebase sweep in progress |

## Verification
Directed cases come first:
- A fill followed by a lookup through an aliased source ID separates correct index decoding from use of the full ID.
- A faulted fill over live data shows whether a fault can overwrite the entry.
- Device flushes with a partial function mask, applied over a fully filled bus, show which devfn bits take part in the compare and whether neighbouring buses are spared.
- A fill at generation 1 followed by enough flushes to wrap the counter separates a real sweep from a bare counter reset, because the stale tag 1 would otherwise hit again.
- Same-cycle fill with invalidation, and same-cycle fill with lookup, pin down which operation wins.

A seeded random mix of fills, faulted fills, lookups and every flush kind, checked against a valid/data model, then crosses several counter wraps with live traffic.

// File: rtl/ctx_cache_pkg.sv
package ctx_cache_pkg;

  typedef enum logic [1:0] {
    INV_NONE   = 2'b00,
    INV_GLOBAL = 2'b01,
    INV_DOMAIN = 2'b10,
    INV_DEVICE = 2'b11
  } inv_kind_e;

  localparam int SID_W  = 16;
  localparam int HALF_W = 64;
  localparam int ENT_W  = 2 * HALF_W;

  // Function-mask code to devfn compare-ignore mask (low three bits).
  function automatic logic [2:0] fmask_ignore(input logic [1:0] code);
    case (code)
      2'd0:    return 3'b000;
      2'd1:    return 3'b100;
      2'd2:    return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/ctx_gen_ctrl.sv
module ctx_gen_ctrl #(
  parameter int GEN_W   = 4,
  parameter int IDX_W   = 5,
  parameter int ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bump,
  output logic [GEN_W-1:0]   gen,
  output logic               busy,
  output logic [ENTRIES-1:0] sweep_clr
);
  localparam logic [GEN_W-1:0] GEN_MAX   = {GEN_W{1'b1}};
  localparam logic [GEN_W-1:0] GEN_FIRST = GEN_W'(1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(ENTRIES - 1);

  logic [GEN_W-1:0] gen_q;
  logic [GEN_W-1:0] gen_inc;
  logic [IDX_W-1:0] ptr_q;
  logic             busy_q;

  assign gen_inc = gen_q + GEN_FIRST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q  <= GEN_FIRST;
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (busy_q) begin
        ptr_q <= ptr_q + IDX_W'(1);
        if (ptr_q == LAST_IDX) busy_q <= 1'b0;
      end
      if (bump) begin
        if (gen_inc == GEN_MAX) begin
          gen_q  <= GEN_FIRST;
          busy_q <= 1'b1;
          ptr_q  <= '0;
        end else begin
          gen_q <= gen_inc;
        end
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_sweep
    assign sweep_clr[i] = busy_q && (ptr_q == IDX_W'(i));
  end

  assign gen  = gen_q;
  assign busy = busy_q;
endmodule

// File: rtl/ctx_dev_match.sv
module ctx_dev_match
  import ctx_cache_pkg::*;
#(
  parameter int BUS_BITS   = 2,
  parameter int DEVFN_BITS = 3,
  parameter int ENTRIES    = 32
) (
  input  logic                  en,
  input  logic [BUS_BITS-1:0]   bus,
  input  logic [DEVFN_BITS-1:0] devfn,
  input  logic [1:0]            fmask,
  output logic [ENTRIES-1:0]    match
);
  localparam int DEVFN_N = 1 << DEVFN_BITS;

  logic [DEVFN_BITS-1:0] care;

  // DEVFN_BITS is at least 3 so the whole ignore mask fits.
  assign care = ~DEVFN_BITS'(fmask_ignore(fmask));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam int EB = i / DEVFN_N;
    localparam int ED = i % DEVFN_N;
    assign match[i] = en && (bus == BUS_BITS'(EB)) &&
                      (((devfn ^ DEVFN_BITS'(ED)) & care) == '0);
  end
endmodule

// File: rtl/ctx_entry_store.sv
module ctx_entry_store #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5,
  parameter int GEN_W   = 4,
  parameter int DATA_W  = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] clr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [GEN_W-1:0]   gen,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_hit,
  output logic [DATA_W-1:0]  rd_data
);
  logic [GEN_W-1:0]  tag_q  [ENTRIES];
  logic [DATA_W-1:0] data_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic wr_here;
    assign wr_here = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)       tag_q[i] <= '0;
      else if (clr[i])  tag_q[i] <= '0;
      else if (wr_here) tag_q[i] <= gen;
    end

    always_ff @(posedge clk) begin
      if (wr_here) data_q[i] <= wr_data;
    end
  end

  assign rd_hit  = (tag_q[rd_idx] == gen);
  assign rd_data = rd_hit ? data_q[rd_idx] : '0;
endmodule

// File: rtl/ctx_cache.sv
module ctx_cache
  import ctx_cache_pkg::*;
#(
  parameter int BUS_BITS   = 2,
  parameter int DEVFN_BITS = 3,
  parameter int GEN_W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lk_valid,
  output logic         lk_ready,
  input  logic [15:0]  lk_sid,
  output logic         rsp_valid,
  output logic         rsp_hit,
  output logic [15:0]  rsp_sid,
  output logic [127:0] rsp_entry,
  input  logic         fill_valid,
  output logic         fill_ready,
  input  logic         fill_fault,
  input  logic [15:0]  fill_sid,
  input  logic [127:0] fill_entry,
  input  logic [1:0]   inv_kind,
  input  logic [15:0]  inv_sid,
  input  logic [1:0]   inv_fmask,
  output logic         busy
);
  localparam int IDX_W   = BUS_BITS + DEVFN_BITS;
  localparam int ENTRIES = 1 << IDX_W;

  inv_kind_e          kind;
  logic               bump;
  logic               dev_en;
  logic [GEN_W-1:0]   gen_q;
  logic               busy_w;
  logic [ENTRIES-1:0] sweep_clr;
  logic [ENTRIES-1:0] dev_clr;
  logic [IDX_W-1:0]   lk_idx;
  logic [IDX_W-1:0]   fill_idx;
  logic               fill_take;
  logic               lk_take;
  logic               rd_hit;
  logic [ENT_W-1:0]   rd_data;

  assign kind   = inv_kind_e'(inv_kind);
  assign bump   = (kind == INV_GLOBAL) || (kind == INV_DOMAIN);
  assign dev_en = (kind == INV_DEVICE);

  assign lk_idx   = {lk_sid[8 +: BUS_BITS], lk_sid[0 +: DEVFN_BITS]};
  assign fill_idx = {fill_sid[8 +: BUS_BITS], fill_sid[0 +: DEVFN_BITS]};

  assign lk_ready   = !busy_w;
  assign fill_ready = !busy_w;
  assign lk_take    = lk_valid && !busy_w;
  assign fill_take  = fill_valid && !busy_w && !fill_fault;
  assign busy       = busy_w;

  ctx_gen_ctrl #(.GEN_W(GEN_W), .IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .bump      (bump),
    .gen       (gen_q),
    .busy      (busy_w),
    .sweep_clr (sweep_clr)
  );

  ctx_dev_match #(.BUS_BITS(BUS_BITS), .DEVFN_BITS(DEVFN_BITS),
                  .ENTRIES(ENTRIES)) u_match (
    .en    (dev_en),
    .bus   (inv_sid[8 +: BUS_BITS]),
    .devfn (inv_sid[0 +: DEVFN_BITS]),
    .fmask (inv_fmask),
    .match (dev_clr)
  );

  ctx_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .GEN_W(GEN_W),
                    .DATA_W(ENT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sweep_clr | dev_clr),
    .wr_en   (fill_take),
    .wr_idx  (fill_idx),
    .wr_data (fill_entry),
    .gen     (gen_q),
    .rd_idx  (lk_idx),
    .rd_hit  (rd_hit),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_sid   <= '0;
      rsp_entry <= '0;
    end else begin
      rsp_valid <= lk_take;
      if (lk_take) begin
        rsp_hit   <= rd_hit;
        rsp_sid   <= lk_sid;
        rsp_entry <= rd_data;
      end
    end
  end
endmodule

// File: rtl/ctx_cache_chk.sv
module ctx_cache_chk #(
  parameter int GEN_W   = 4,
  parameter int ENTRIES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             fill_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [127:0]     rsp_entry,
  input logic [1:0]       inv_kind,
  input logic             busy,
  input logic [GEN_W-1:0] gen
);
  localparam logic [GEN_W-1:0] GMAX = {GEN_W{1'b1}};

  logic bump;
  logic [31:0] busy_cnt;
  assign bump = (inv_kind == 2'b01) || (inv_kind == 2'b10);

  always_ff @(posedge clk) begin
    if (!rst_n)                           busy_cnt <= '0;
    else if (bump && gen == GMAX - 1'b1)  busy_cnt <= '0;
    else if (busy)                        busy_cnt <= busy_cnt + 1;
    else                                  busy_cnt <= '0;
  end

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!lk_ready && !fill_ready));

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  a_r2_rsp_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !rsp_valid);

  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_entry == '0));

  a_r6_bump: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && gen != GMAX - 1'b1) |=> (gen == GEN_W'($past(gen) + 1'b1)));

  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && gen == GMAX - 1'b1) |=> (gen == GEN_W'(1) && busy));

  a_r9_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(gen));

  a_r1_gen_range: assert property (@(posedge clk) disable iff (!rst_n)
    (gen != '0) && (gen != GMAX));

  a_r10_sweep_len: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < ENTRIES));
endmodule

bind ctx_cache ctx_cache_chk #(.GEN_W(GEN_W), .ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .fill_ready (fill_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_entry  (rsp_entry),
  .inv_kind   (inv_kind),
  .busy       (busy),
  .gen        (gen_q)
);

// File: tb/ctx_cache_test.sv
module ctx_cache_test;
  localparam int BUS_BITS   = 2;
  localparam int DEVFN_BITS = 3;
  localparam int GEN_W      = 4;
  localparam int ENTRIES    = 1 << (BUS_BITS + DEVFN_BITS);
  localparam int GWRAP      = (1 << GEN_W) - 2;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         lk_valid = 0;
  logic         lk_ready;
  logic [15:0]  lk_sid = '0;
  logic         rsp_valid, rsp_hit;
  logic [15:0]  rsp_sid;
  logic [127:0] rsp_entry;
  logic         fill_valid = 0, fill_ready, fill_fault = 0;
  logic [15:0]  fill_sid = '0;
  logic [127:0] fill_entry = '0;
  logic [1:0]   inv_kind = 2'b00;
  logic [15:0]  inv_sid = '0;
  logic [1:0]   inv_fmask = 2'b00;
  logic         busy;

  ctx_cache #(.BUS_BITS(BUS_BITS), .DEVFN_BITS(DEVFN_BITS), .GEN_W(GEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_sid(lk_sid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_sid(rsp_sid), .rsp_entry(rsp_entry), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_fault(fill_fault), .fill_sid(fill_sid),
    .fill_entry(fill_entry), .inv_kind(inv_kind), .inv_sid(inv_sid),
    .inv_fmask(inv_fmask), .busy(busy)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, gsince = 0;
  bit           exp_v [ENTRIES];
  logic [127:0] exp_d [ENTRIES];

  function automatic int idx_of(input logic [15:0] s);
    return ((s >> 8) % (1 << BUS_BITS)) * (1 << DEVFN_BITS) +
           (s % (1 << DEVFN_BITS));
  endfunction

  function automatic int ign_of(input logic [1:0] fm);
    case (fm)
      2'd0: return 0;
      2'd1: return 4;
      2'd2: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < ENTRIES; i++) begin
      exp_v[i] = 0;
      exp_d[i] = '0;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    clear_model();
    gsince = 0;
  endtask

  task automatic lookup(input logic [15:0] s, input string req);
    int ix;
    ix = idx_of(s);
    lk_valid = 1;
    lk_sid = s;
    @(negedge clk);
    lk_valid = 0;
    chk({req, " rsp_valid"}, rsp_valid, 1'b1);
    chk({req, " hit"}, rsp_hit, exp_v[ix]);
    chk({req, " entry"}, rsp_entry, exp_v[ix] ? exp_d[ix] : 128'd0);
    chk({req, " sid"}, rsp_sid, s);
  endtask

  task automatic fill(input logic [15:0] s, input logic [127:0] d,
                      input bit fault);
    fill_valid = 1;
    fill_sid = s;
    fill_entry = d;
    fill_fault = fault;
    @(negedge clk);
    fill_valid = 0;
    fill_fault = 0;
    if (!fault) begin
      exp_v[idx_of(s)] = 1;
      exp_d[idx_of(s)] = d;
    end
  endtask

  task automatic model_dev(input logic [15:0] s, input logic [1:0] fm);
    int care;
    care = 7 & ~ign_of(fm);
    for (int i = 0; i < ENTRIES; i++) begin
      if ((i >> DEVFN_BITS) == ((s >> 8) % (1 << BUS_BITS)) &&
          (((i ^ s) & care) == 0))
        exp_v[i] = 0;
    end
  endtask

  task automatic inv(input logic [1:0] k, input logic [15:0] s,
                     input logic [1:0] fm);
    inv_kind = k;
    inv_sid = s;
    inv_fmask = fm;
    @(negedge clk);
    inv_kind = 2'b00;
    if (k == 2'b11) model_dev(s, fm);
    if (k == 2'b01 || k == 2'b10) begin
      clear_model();
      gsince++;
      if (gsince == GWRAP) begin
        int cnt;
        gsince = 0;
        cnt = 0;
        chk("R10 busy after wrap", busy, 1'b1);
        while (busy && cnt < 4 * ENTRIES) begin
          chk("R10 lk_ready low", lk_ready, 1'b0);
          cnt++;
          @(negedge clk);
        end
        chk("R10 busy length", cnt, ENTRIES);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] d0;
    void'($urandom(32'hC0FFEE01));
    do_reset();

    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 lk_ready", lk_ready, 1'b1);
    chk("R1 fill_ready", fill_ready, 1'b1);
    lookup(16'h0102, "R1 miss after reset");

    // R4 fill then hit; R3 aliasing through upper bits
    d0 = rnd128();
    fill(16'hF9FA, d0, 0);
    lookup(16'h0502, "R3 R4 aliased hit");
    // R5 faulted fill keeps old data
    fill(16'h0102, rnd128(), 1);
    lookup(16'h0102, "R5 fault no update");
    // R9 none kind
    inv(2'b00, 16'h0102, 2'd3);
    lookup(16'h0102, "R9 no effect");
    // R6 global
    inv(2'b01, 16'h0000, 2'd0);
    lookup(16'h0102, "R6 global miss");
    fill(16'h0102, rnd128(), 0);
    lookup(16'h0102, "R6 refill hit");
    // R7 domain
    inv(2'b10, 16'h0000, 2'd0);
    lookup(16'h0102, "R7 domain miss");

    // R8 device-selective with partial mask
    for (int f = 0; f < 8; f++) fill(16'h0100 | 16'(f), rnd128(), 0);
    fill(16'h0205, rnd128(), 0);
    inv(2'b11, 16'h0105, 2'd2);
    for (int f = 0; f < 8; f++) lookup(16'h0100 | 16'(f), "R8 device mask");
    lookup(16'h0205, "R8 other bus kept");
    inv(2'b11, 16'h0104, 2'd0);
    lookup(16'h0104, "R8 exact devfn");
    lookup(16'h0106, "R8 neighbour kept");

    // R11 fill and device flush of same entry together
    inv_kind = 2'b11;
    inv_sid = 16'h0303;
    inv_fmask = 2'd0;
    fill(16'h0303, rnd128(), 0);
    inv_kind = 2'b00;
    exp_v[idx_of(16'h0303)] = 0;
    lookup(16'h0303, "R11 invalidation wins");

    // R12 lookup concurrent with fill sees old state
    lk_valid = 1;
    lk_sid = 16'h0007;
    fill(16'h0007, rnd128(), 0);
    lk_valid = 0;
    chk("R12 concurrent lookup miss", rsp_hit, 1'b0);
    lookup(16'h0007, "R12 later hit");

    // R10 wrap sweep removes stale generation-1 tag
    do_reset();
    fill(16'h0201, rnd128(), 0);
    exp_v[idx_of(16'h0201)] = 1;
    for (int g = 0; g < GWRAP; g++) inv(2'b01, 16'h0000, 2'd0);
    lookup(16'h0201, "R10 miss after rebase");
    fill(16'h0201, rnd128(), 0);
    lookup(16'h0201, "R10 fill after rebase");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int r;
      logic [15:0] s;
      r = $urandom % 16;
      s = 16'($urandom);
      if (r < 6)       fill(s, rnd128(), ($urandom % 8) == 0);
      else if (r < 12) lookup(s, "R2 random lookup");
      else if (r == 12) inv(2'b01, s, 2'd0);
      else if (r == 13) inv(2'b10, s, 2'd0);
      else if (r == 14) inv(2'b11, s, 2'($urandom));
      else             inv(2'b00, s, 2'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule